// File: doc/BRIEF.md
# Dual-Pin Edge-Selectable Interrupt Controller

This block turns two asynchronous external pins, a general-purpose interrupt pin and a vertical sync pin, into clean interrupt requests. Each pin first passes through a two-flop synchronizer. A debounce counter follows it, and a new level is accepted only after it has held steady for `FILT_CYCLES` clocks. The default of 50 clocks equals 1 µs at 50 MHz, so shorter pulses never reach the logic behind the filter.

The general pin has a second qualifier stage. A 4-bit width setting asks the filtered level to hold for a further `width × FILT_CYCLES` clocks before it counts. Each channel has a polarity flag that picks which edge of its qualified level raises a one-clock request. Software writes the flags over a small address/data bus and can read back the qualified level of both pins. The controller does no priority, masking or vectoring. A downstream interrupt unit consumes the request pulses.

Top module: `dual_edge_irq`

## Requirements
- R1: After reset, both polarity flags are 0, the width setting is 0, both qualified levels are 0, and no request is asserted.
- R2: Address 0x1F holds the polarity flags: bit 0 for the general pin and bit 1 for the vsync pin. A flag value of 0 selects the rising edge and 1 selects the falling edge. Bits 3:2 of this register read 0.
- R3: Address 0x0F is read-only. Bit 0 gives the qualified general level, bit 1 gives the filtered vsync level, and bits 3:2 read 0. A write to this address changes nothing.
- R4: On either pin, a level that holds at the synchronizer output for fewer than `FILT_CYCLES` consecutive clocks is discarded. It produces no request and no level change.
- R5: A pin change that is held long enough is accepted on the `FILT_CYCLES`-th clock edge after it reaches the second synchronizer flop. With width 0, the request is high in the cycle after that edge.
- R6: Each request is a single-clock pulse. It is raised only on the level transition that matches the channel's polarity flag.
- R7: Writing a polarity flag while the levels are steady raises no request.
- R8: Address 0x17 bits 3:0 hold the general-pin width W. W = 0 bypasses the qualifier. For W > 0, the filtered general level must differ from the qualified level for W·`FILT_CYCLES` consecutive clocks before the qualified level follows it. Shorter filtered pulses raise no request.
- R9: Any address other than 0x0F, 0x17 and 0x1F reads 0. A write to such an address has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| gen_pin | input | 1 | Asynchronous general interrupt pin |
| vsync_pin | input | 1 | Asynchronous vertical sync pin |
| bus_addr | input | 5 | Control register address |
| bus_wdata | input | 4 | Write data |
| bus_we | input | 1 | Write strobe, one register write per cycle it is high |
| bus_rdata | output | 4 | Combinational read data for `bus_addr` |
| gen_irq | output | 1 | One-cycle request from the general pin |
| vsync_irq | output | 1 | One-cycle request from the vsync pin |

## Verification
The hardest case to reach is a pulse that passes the debounce filter but is cut off by the width qualifier. The stimulus sets W = 2 and then drives a general-pin pulse long enough to clear the filter but shorter than 2·`FILT_CYCLES` at the filtered level. It follows with a longer pulse that must get through. A second delicate case is toggling a polarity flag while the vsync level is held high. Here the only difference between a correct and a faulty design is whether a request appears. A behavioural cycle model tracks both cases every clock.

// File: rtl/dual_edge_irq.sv
module dual_edge_irq #(
  parameter int FILT_CYCLES = 50
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       gen_pin,
  input  logic       vsync_pin,
  input  logic [4:0] bus_addr,
  input  logic [3:0] bus_wdata,
  input  logic       bus_we,
  output logic [3:0] bus_rdata,
  output logic       gen_irq,
  output logic       vsync_irq
);
  localparam int          CW         = $clog2(FILT_CYCLES + 1);
  localparam int          QW         = $clog2(15 * FILT_CYCLES + 1);
  localparam logic [4:0]  ADDR_LEVEL = 5'h0F;
  localparam logic [4:0]  ADDR_WIDTH = 5'h17;
  localparam logic [4:0]  ADDR_EDGE  = 5'h1F;

  logic [1:0]    meta, sync, filt, pol, prev, lvl;
  logic [CW-1:0] fcnt [2];
  logic [3:0]    wsel;
  logic [QW-1:0] qcnt;
  logic          qreg;
  logic [QW-1:0] qlim;

  assign qlim = QW'(wsel) * QW'(FILT_CYCLES);
  assign lvl  = {filt[1], (wsel == 4'd0) ? filt[0] : qreg};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta <= '0;
      sync <= '0;
      filt <= '0;
      pol  <= '0;
      prev <= '0;
      wsel <= '0;
      qcnt <= '0;
      qreg <= 1'b0;
      for (int i = 0; i < 2; i++) fcnt[i] <= '0;
    end else begin
      meta <= {vsync_pin, gen_pin};
      sync <= meta;
      for (int i = 0; i < 2; i++) begin
        if (sync[i] == filt[i]) begin
          fcnt[i] <= '0;
        end else if (fcnt[i] == CW'(FILT_CYCLES - 1)) begin
          filt[i] <= sync[i];
          fcnt[i] <= '0;
        end else begin
          fcnt[i] <= fcnt[i] + 1'b1;
        end
      end
      if (filt[0] == qreg) begin
        qcnt <= '0;
      end else if (wsel == 4'd0 || qcnt == qlim - 1'b1) begin
        qreg <= filt[0];
        qcnt <= '0;
      end else begin
        qcnt <= qcnt + 1'b1;
      end
      prev <= lvl;
      if (bus_we) begin
        if (bus_addr == ADDR_EDGE)  pol  <= bus_wdata[1:0];
        if (bus_addr == ADDR_WIDTH) wsel <= bus_wdata;
      end
    end
  end

  assign gen_irq   = (prev[0] ^ lvl[0]) & (lvl[0] ^ pol[0]);
  assign vsync_irq = (prev[1] ^ lvl[1]) & (lvl[1] ^ pol[1]);

  always_comb begin
    case (bus_addr)
      ADDR_EDGE:  bus_rdata = {2'b00, pol};
      ADDR_LEVEL: bus_rdata = {2'b00, lvl};
      ADDR_WIDTH: bus_rdata = wsel;
      default:    bus_rdata = 4'h0;
    endcase
  end
endmodule

module dual_edge_irq_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       gen_irq,
  input logic       vsync_irq,
  input logic [1:0] lvl,
  input logic [1:0] sync,
  input logic [1:0] filt,
  input logic [4:0] bus_addr,
  input logic [3:0] bus_rdata
);
  // R6
  irq_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (gen_irq || vsync_irq) |=> (!$past(gen_irq) || !gen_irq) && (!$past(vsync_irq) || !vsync_irq));

  // R7
  irq_needs_change_chk: assert property (@(posedge clk) disable iff (!rst_n)
    gen_irq |-> (lvl[0] != $past(lvl[0])));

  // R4
  filt_follows_sync_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(filt[1]) |-> ($past(sync[1]) && $past(sync[1], 2)));

  // R9
  unmapped_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr != 5'h0F && bus_addr != 5'h17 && bus_addr != 5'h1F) |-> (bus_rdata == 4'h0));

  // R2
  edge_upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr == 5'h1F || bus_addr == 5'h0F) |-> (bus_rdata[3:2] == 2'b00));
endmodule

bind dual_edge_irq dual_edge_irq_chk u_chk (
  .clk(clk), .rst_n(rst_n), .gen_irq(gen_irq), .vsync_irq(vsync_irq),
  .lvl(lvl), .sync(sync), .filt(filt), .bus_addr(bus_addr), .bus_rdata(bus_rdata)
);

// File: tb/dual_edge_irq_bench.sv
module dual_edge_irq_bench;
  localparam int CLK_PERIOD = 10;
  localparam int N = 6;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       gen_pin = 1'b0, vsync_pin = 1'b0;
  logic [4:0] bus_addr = 5'h0F;
  logic [3:0] bus_wdata = 4'h0;
  logic       bus_we = 1'b0;
  logic [3:0] bus_rdata;
  logic       gen_irq, vsync_irq;

  int checks = 0, fails = 0;
  int gen_cnt = 0, vs_cnt = 0;

  dual_edge_irq #(.FILT_CYCLES(N)) u_dual_edge_irq (
    .clk(clk), .rst_n(rst_n), .gen_pin(gen_pin), .vsync_pin(vsync_pin),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_we(bus_we),
    .bus_rdata(bus_rdata), .gen_irq(gen_irq), .vsync_irq(vsync_irq)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // behavioural reference model
  bit m_s1[2], m_s2[2], m_f[2], m_prev[2], m_lvl[2], m_pol[2];
  int m_cnt[2];
  bit m_q;
  int m_qc, m_w;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      foreach (m_s1[i]) begin
        m_s1[i] = 0; m_s2[i] = 0; m_f[i] = 0; m_prev[i] = 0;
        m_lvl[i] = 0; m_pol[i] = 0; m_cnt[i] = 0;
      end
      m_q = 0; m_qc = 0; m_w = 0;
    end else begin
      m_prev[0] = m_lvl[0];
      m_prev[1] = m_lvl[1];
      if (m_f[0] == m_q) m_qc = 0;
      else if (m_w == 0 || m_qc == m_w * N - 1) begin m_q = m_f[0]; m_qc = 0; end
      else m_qc++;
      for (int i = 0; i < 2; i++) begin
        if (m_s2[i] == m_f[i]) m_cnt[i] = 0;
        else if (m_cnt[i] == N - 1) begin m_f[i] = m_s2[i]; m_cnt[i] = 0; end
        else m_cnt[i]++;
        m_s2[i] = m_s1[i];
      end
      m_s1[0] = gen_pin;
      m_s1[1] = vsync_pin;
      if (bus_we && bus_addr == 5'h1F) begin m_pol[0] = bus_wdata[0]; m_pol[1] = bus_wdata[1]; end
      if (bus_we && bus_addr == 5'h17) m_w = bus_wdata;
      m_lvl[0] = (m_w == 0) ? m_f[0] : m_q;
      m_lvl[1] = m_f[1];
    end
  end

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n) begin
      bit eg, ev;
      logic [3:0] er;
      string rq;
      eg = (m_prev[0] != m_lvl[0]) && (m_lvl[0] != m_pol[0]);
      ev = (m_prev[1] != m_lvl[1]) && (m_lvl[1] != m_pol[1]);
      check("R6 gen_irq", gen_irq, eg);
      check("R6 vsync_irq", vsync_irq, ev);
      case (bus_addr)
        5'h1F: begin er = {2'b00, m_pol[1], m_pol[0]}; rq = "R2 rdata"; end
        5'h0F: begin er = {2'b00, m_lvl[1], m_lvl[0]}; rq = "R3 rdata"; end
        5'h17: begin er = 4'(m_w); rq = "R8 rdata"; end
        default: begin er = 4'h0; rq = "R9 rdata"; end
      endcase
      check(rq, bus_rdata, er);
      if (gen_irq) gen_cnt++;
      if (vsync_irq) vs_cnt++;
    end
  end

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [4:0] a, input logic [3:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_we = 1'b1;
    @(negedge clk);
    bus_we = 1'b0; bus_addr = 5'h0F;
  endtask

  task automatic rd(input logic [4:0] a, input string req, input int exp);
    @(negedge clk);
    bus_addr = a;
    #1 check(req, bus_rdata, exp);
    @(negedge clk);
    bus_addr = 5'h0F;
  endtask

  task automatic pulse(input bit ch, input int len);
    @(negedge clk);
    if (ch) vsync_pin = 1'b1; else gen_pin = 1'b1;
    cyc(len);
    if (ch) vsync_pin = 1'b0; else gen_pin = 1'b0;
    cyc(40);
  endtask

  initial begin
    cyc(3);
    #1 check("R1 gen_irq reset", gen_irq, 0);
    check("R1 vsync_irq reset", vsync_irq, 0);
    check("R1 level reset", bus_rdata, 0);
    rst_n = 1'b1;
    rd(5'h1F, "R1 polarity reset", 0);
    rd(5'h17, "R1 width reset", 0);

    gen_cnt = 0; vs_cnt = 0;
    pulse(0, N - 2);
    pulse(1, N - 2);
    check("R4 short pulses gen", gen_cnt, 0);
    check("R4 short pulses vsync", vs_cnt, 0);

    gen_cnt = 0;
    pulse(0, N + 4);
    check("R5 long gen rising", gen_cnt, 1);

    wr(5'h1F, 4'hF);
    rd(5'h1F, "R2 upper bits zero", 3);
    vs_cnt = 0;
    pulse(1, N + 6);
    check("R6 vsync falling only", vs_cnt, 1);

    @(negedge clk); vsync_pin = 1'b1;
    cyc(30);
    rd(5'h0F, "R3 vsync level high", 2);
    vs_cnt = 0; gen_cnt = 0;
    wr(5'h1F, 4'h0); cyc(3);
    wr(5'h1F, 4'h2); cyc(3);
    wr(5'h1F, 4'h0); cyc(3);
    check("R7 polarity toggle vsync", vs_cnt, 0);
    check("R7 polarity toggle gen", gen_cnt, 0);
    wr(5'h0F, 4'h0);
    rd(5'h0F, "R3 write ignored", 2);
    @(negedge clk); vsync_pin = 1'b0;
    cyc(30);

    wr(5'h17, 4'h2);
    rd(5'h17, "R8 width readback", 2);
    gen_cnt = 0;
    pulse(0, 2 * N - 4);
    check("R8 qualified short gen", gen_cnt, 0);
    pulse(0, 2 * N + 8);
    check("R8 qualified long gen", gen_cnt, 1);

    wr(5'h05, 4'hF);
    rd(5'h05, "R9 unmapped read", 0);
    rd(5'h1F, "R9 unmapped write harmless", 0);
    cyc(5);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 100000);
    checks++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule